// File: doc/BRIEF.md
# CPU Exception Acceptance Arbiter

This block sits next to a small CPU sequencer. At every boundary, meaning the end of an instruction or the end of exception handling, it chooses which pending exception starts next, if any. Four sources compete for that slot: reset, trace, a maskable interrupt and a trap instruction. A rising edge on either of two active-low reset pins starts reset handling, and so does a watchdog overflow pulse. Reset can abort handling that is already in progress. The other three sources are judged only at boundaries. The sequencer reports each boundary with a strobe that carries the class of the instruction that has just completed. That class can suppress trace, or suppress interrupt sampling, at that one boundary.

When an exception is accepted, the block pulses one bit of a one-hot grant vector for a single cycle. It also presents the handler's vector address and raises busy. Busy stays high until the sequencer reports that the handling has finished. While either reset pin is held low, the block stays in a quiet reset state. A reset-kind flag shows whether that state is a power-on reset or a manual reset.

Top module: `exc_arbiter`

## Requirements
- R1: The grant output `grant_o` has at most one bit set, and that bit is set for exactly one cycle. The bits are: bit 0 reset, bit 1 trace, bit 2 interrupt, bit 3 trap. When several sources qualify in the same cycle, the winner follows the priority reset > trace > interrupt > trap.
- R2: Reset is granted on the first clock edge at which a reset pin is sampled high after having been sampled low. A `wdt_ovf_i` pulse while both pins are high also grants reset on that edge. A reset grant is made even while `busy_o` is high.
- R3: On any edge where a reset pin is sampled low, the next cycle shows no grant and `busy_o` low, and any latched trap is discarded. On that edge `rst_kind_o` becomes 0 (power-on) if `por_n_i` is low, otherwise 1 (manual), so power-on wins when both pins are low. A watchdog overflow with both pins high sets `rst_kind_o` to 0.
- R4: At a boundary, trace qualifies only when `trace_flag_i` is 1, `int_mode_i` equals 2, and the class is not return-from-exception.
- R5: At a boundary, an interrupt qualifies when `irq_req_i` is high, except when the class is control-register-modify or end-of-reset-handling.
- R6: A `trap_i` strobe is latched whatever the mode, flags or busy state are, except while a reset pin is low. The latched trap is granted at the first later boundary (or the strobe's own boundary) where no higher source wins. Until then it stays pending.
- R7: The `bnd_cls_i` encoding is 0 normal, 1 return-from-exception, 2 control-register-modify, 3 end-of-reset-handling. Codes 4 to 7 behave as normal.
- R8: With every grant, `vec_addr_o` becomes VEC_BASE + 4 × vector number. The vector numbers are 0 for reset, 5 for trace, 8 for trap, and `irq_vec_i` for an interrupt. Between grants `vec_addr_o` holds its value.
- R9: Any grant sets `busy_o`. A `done_i` pulse in a cycle with no grant clears `busy_o`. Boundaries that arrive while `busy_o` is high produce no trace, interrupt or trap grant.
- R10: A synchronous `rst` gives `grant_o`=0, `busy_o`=0, `rst_kind_o`=0 and `vec_addr_o`=VEC_BASE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| por_n_i | input | 1 | Power-on reset pin, active low |
| mrst_n_i | input | 1 | Manual reset pin, active low |
| wdt_ovf_i | input | 1 | Watchdog overflow pulse |
| trace_flag_i | input | 1 | Trace flag from the status register |
| int_mode_i | input | 2 | Interrupt control mode |
| irq_req_i | input | 1 | Pending interrupt request |
| irq_vec_i | input | VEC_W | Vector number of the pending interrupt |
| trap_i | input | 1 | Trap-instruction strobe |
| bnd_i | input | 1 | Boundary strobe |
| bnd_cls_i | input | 3 | Class of the instruction that just completed |
| done_i | input | 1 | Exception handling finished |
| grant_o | output | 4 | One-hot grant pulse |
| rst_kind_o | output | 1 | 0 power-on reset, 1 manual reset |
| vec_addr_o | output | ADDR_W | Vector address of the last grant |
| busy_o | output | 1 | Exception handling in progress |

## Verification
The hardest case to reach from the ports is a trap that waits across several boundaries. It is outranked first by trace and then by an interrupt, and meanwhile reset and busy periods drain or block it. The stimulus gets there by strobing the trap while trace is enabled, then walking boundaries with interrupts pending and with done pulses held back. A long random phase then mixes reset pulses, busy windows and every class code. A behavioural reference model checks each of these paths on every cycle.

// File: rtl/exc_pkg.sv
package exc_pkg;

    typedef enum logic [2:0] {
        CLS_NORMAL = 3'd0,
        CLS_RTE    = 3'd1,
        CLS_CTRL   = 3'd2,
        CLS_ENDRST = 3'd3
    } cls_e;

    typedef enum logic {
        KIND_POWERON = 1'b0,
        KIND_MANUAL  = 1'b1
    } rkind_e;

    localparam int NSRC  = 4;
    localparam int G_RST = 0;
    localparam int G_TRC = 1;
    localparam int G_IRQ = 2;
    localparam int G_TRP = 3;

    localparam logic [1:0] TRACE_MODE = 2'd2;

    function automatic logic trace_blocked(cls_e c);
        return c == CLS_RTE;
    endfunction

    function automatic logic irq_blocked(cls_e c);
        return (c == CLS_CTRL) || (c == CLS_ENDRST);
    endfunction

endpackage

// File: rtl/exc_pin_watch.sv
module exc_pin_watch
    import exc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   por_n_i,
    input  logic   mrst_n_i,
    input  logic   wdt_ovf_i,
    output logic   hold_o,
    output logic   evt_o,
    output rkind_e kind_o
);
    logic   por_q;
    logic   mr_q;
    rkind_e kind_q;

    assign hold_o = !por_n_i || !mrst_n_i;
    assign evt_o  = (por_n_i && !por_q) || (mrst_n_i && !mr_q) || wdt_ovf_i;
    assign kind_o = kind_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            por_q  <= 1'b1;
            mr_q   <= 1'b1;
            kind_q <= KIND_POWERON;
        end else begin
            por_q <= por_n_i;
            mr_q  <= mrst_n_i;
            if (!por_n_i)
                kind_q <= KIND_POWERON;
            else if (!mrst_n_i)
                kind_q <= KIND_MANUAL;
            else if (wdt_ovf_i)
                kind_q <= KIND_POWERON;
        end
    end

    AST_POR_WINS: assert property (@(posedge clk) disable iff (rst)
        !por_n_i |=> kind_o == KIND_POWERON); // R3

    AST_MANUAL_KIND: assert property (@(posedge clk) disable iff (rst)
        (por_n_i && !mrst_n_i) |=> kind_o == KIND_MANUAL); // R3

endmodule

// File: rtl/exc_select.sv
module exc_select
    import exc_pkg::*;
#(
    parameter int VEC_W     = 8,
    parameter int TRC_VNUM  = 5,
    parameter int TRAP_VNUM = 8
) (
    input  logic             bnd_i,
    input  logic [2:0]       bnd_cls_i,
    input  logic             blocked_i,
    input  logic             trace_flag_i,
    input  logic [1:0]       int_mode_i,
    input  logic             irq_req_i,
    input  logic [VEC_W-1:0] irq_vec_i,
    input  logic             trap_any_i,
    output logic [NSRC-1:0]  grant_o,
    output logic [VEC_W-1:0] vnum_o
);
    cls_e cls;
    logic open_w;
    logic trc_ok;
    logic irq_ok;
    logic trp_ok;

    assign cls    = cls_e'(bnd_cls_i);
    assign open_w = bnd_i && !blocked_i;
    assign trc_ok = open_w && trace_flag_i && (int_mode_i == TRACE_MODE) && !trace_blocked(cls);
    assign irq_ok = open_w && irq_req_i && !irq_blocked(cls);
    assign trp_ok = open_w && trap_any_i;

    always_comb begin
        grant_o = '0;
        vnum_o  = '0;
        if (trc_ok) begin
            grant_o[G_TRC] = 1'b1;
            vnum_o         = VEC_W'(TRC_VNUM);
        end else if (irq_ok) begin
            grant_o[G_IRQ] = 1'b1;
            vnum_o         = irq_vec_i;
        end else if (trp_ok) begin
            grant_o[G_TRP] = 1'b1;
            vnum_o         = VEC_W'(TRAP_VNUM);
        end
    end

    always_comb begin
        AST_SEL_ONEHOT: assert ($onehot0(grant_o)); // R1
    end

endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter int          VEC_W     = 8,
    parameter int unsigned VEC_BASE  = 'h100,
    parameter int          RST_VNUM  = 0,
    parameter int          TRC_VNUM  = 5,
    parameter int          TRAP_VNUM = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              por_n_i,
    input  logic              mrst_n_i,
    input  logic              wdt_ovf_i,
    input  logic              trace_flag_i,
    input  logic [1:0]        int_mode_i,
    input  logic              irq_req_i,
    input  logic [VEC_W-1:0]  irq_vec_i,
    input  logic              trap_i,
    input  logic              bnd_i,
    input  logic [2:0]        bnd_cls_i,
    input  logic              done_i,
    output logic [3:0]        grant_o,
    output logic              rst_kind_o,
    output logic [ADDR_W-1:0] vec_addr_o,
    output logic              busy_o
);
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(VEC_BASE);

    function automatic logic [ADDR_W-1:0] addr_of(logic [VEC_W-1:0] n);
        return BASE_A + (ADDR_W'(n) << 2);
    endfunction

    logic              hold;
    logic              evt;
    rkind_e            kind;
    logic [NSRC-1:0]   sel_grant;
    logic [VEC_W-1:0]  sel_vnum;
    logic [NSRC-1:0]   grant_q;
    logic              busy_q;
    logic              trap_q;
    logic [ADDR_W-1:0] vec_q;

    exc_pin_watch u_pins (
        .clk       (clk),
        .rst       (rst),
        .por_n_i   (por_n_i),
        .mrst_n_i  (mrst_n_i),
        .wdt_ovf_i (wdt_ovf_i),
        .hold_o    (hold),
        .evt_o     (evt),
        .kind_o    (kind)
    );

    exc_select #(
        .VEC_W     (VEC_W),
        .TRC_VNUM  (TRC_VNUM),
        .TRAP_VNUM (TRAP_VNUM)
    ) u_sel (
        .bnd_i        (bnd_i),
        .bnd_cls_i    (bnd_cls_i),
        .blocked_i    (busy_q),
        .trace_flag_i (trace_flag_i),
        .int_mode_i   (int_mode_i),
        .irq_req_i    (irq_req_i),
        .irq_vec_i    (irq_vec_i),
        .trap_any_i   (trap_q || trap_i),
        .grant_o      (sel_grant),
        .vnum_o       (sel_vnum)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_q <= '0;
            busy_q  <= 1'b0;
            trap_q  <= 1'b0;
            vec_q   <= BASE_A;
        end else if (hold) begin
            grant_q <= '0;
            busy_q  <= 1'b0;
            trap_q  <= 1'b0;
        end else if (evt) begin
            grant_q        <= '0;
            grant_q[G_RST] <= 1'b1;
            busy_q         <= 1'b1;
            trap_q         <= 1'b0;
            vec_q          <= addr_of(VEC_W'(RST_VNUM));
        end else begin
            grant_q <= sel_grant;
            if (|sel_grant) begin
                busy_q <= 1'b1;
                vec_q  <= addr_of(sel_vnum);
            end else if (done_i) begin
                busy_q <= 1'b0;
            end
            if (sel_grant[G_TRP])
                trap_q <= 1'b0;
            else if (trap_i)
                trap_q <= 1'b1;
        end
    end

    assign grant_o    = grant_q;
    assign busy_o     = busy_q;
    assign vec_addr_o = vec_q;
    assign rst_kind_o = kind;

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_o)); // R1

    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!por_n_i || !mrst_n_i) |=> (grant_o == '0 && !busy_o)); // R3

    AST_TRACE_GATE: assert property (@(posedge clk) disable iff (rst)
        grant_o[G_TRC] |-> ($past(int_mode_i) == TRACE_MODE && $past(trace_flag_i)
                            && $past(bnd_cls_i) != CLS_RTE)); // R4

    AST_IRQ_SKIP: assert property (@(posedge clk) disable iff (rst)
        grant_o[G_IRQ] |-> ($past(bnd_cls_i) != CLS_CTRL && $past(bnd_cls_i) != CLS_ENDRST)); // R5

    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (|grant_o[NSRC-1:1]) |-> (!$past(busy_o) && $past(bnd_i))); // R9

    AST_GRANT_BUSY: assert property (@(posedge clk) disable iff (rst)
        (|grant_o) |-> busy_o); // R9

endmodule

// File: tb/sim_exc_arbiter.sv
module sim_exc_arbiter;
    localparam int CLK_PERIOD = 10;
    localparam int BASE       = 'h100;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        por_n = 1'b1, mrst_n = 1'b1, wdt = 1'b0;
    logic        tflag = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic        irq = 1'b0;
    logic [7:0]  ivec = 8'd0;
    logic        trap = 1'b0, bnd = 1'b0, done = 1'b0;
    logic [2:0]  cls = 3'd0;
    logic [3:0]  grant;
    logic        kind, busy;
    logic [15:0] vaddr;

    int    errors = 0;
    int    checks = 0;
    string cur_req = "R10";

    // reference model state
    int m_grant = 0, m_busy = 0, m_kind = 0, m_vec = BASE;
    int m_por_q = 1, m_mr_q = 1, m_trap = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_arbiter u0 (
        .clk(clk), .rst(rst), .por_n_i(por_n), .mrst_n_i(mrst_n), .wdt_ovf_i(wdt),
        .trace_flag_i(tflag), .int_mode_i(mode), .irq_req_i(irq), .irq_vec_i(ivec),
        .trap_i(trap), .bnd_i(bnd), .bnd_cls_i(cls), .done_i(done),
        .grant_o(grant), .rst_kind_o(kind), .vec_addr_o(vaddr), .busy_o(busy)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_grant = 0; m_busy = 0; m_kind = 0; m_vec = BASE;
            m_por_q = 1; m_mr_q = 1; m_trap = 0;
        end else begin
            int  hold, evt, g, tp, c;
            hold = (!por_n || !mrst_n) ? 1 : 0;
            evt  = ((por_n && m_por_q == 0) || (mrst_n && m_mr_q == 0) || wdt) ? 1 : 0;
            if (!por_n) m_kind = 0;
            else if (!mrst_n) m_kind = 1;
            else if (wdt) m_kind = 0;
            c = int'(cls);
            if (hold) begin
                m_grant = 0; m_busy = 0; m_trap = 0;
            end else if (evt) begin
                m_grant = 1; m_busy = 1; m_trap = 0; m_vec = BASE;
            end else begin
                tp = (m_trap || trap) ? 1 : 0;
                g = 0;
                if (bnd && m_busy == 0) begin
                    if (tflag && mode == 2 && c != 1) begin g = 2; m_vec = BASE + 4*5; end
                    else if (irq && c != 2 && c != 3) begin g = 4; m_vec = BASE + 4*int'(ivec); end
                    else if (tp) begin g = 8; m_vec = BASE + 4*8; tp = 0; end
                end
                if (g != 0) m_busy = 1;
                else if (done) m_busy = 0;
                m_grant = g;
                m_trap = tp;
            end
            m_por_q = por_n ? 1 : 0;
            m_mr_q  = mrst_n ? 1 : 0;
        end
    end

    task automatic chk(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        chk("grant", int'(grant), m_grant);
        chk("busy", int'(busy), m_busy);
        chk("kind", int'(kind), m_kind);
        chk("vec", int'(vaddr), m_vec);
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic boundary(input logic [2:0] c);
        cls = c; bnd = 1'b1; tick(); bnd = 1'b0; cls = 3'd0;
    endtask

    task automatic finish_handling();
        done = 1'b1; tick(); done = 1'b0; tick();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R10: reset state
        cur_req = "R10";
        tick(); tick();
        chk("R10 grant idle", int'(grant), 0);
        chk("R10 vec base", int'(vaddr), BASE);
        rst = 1'b0;
        tick();

        // R3: power-on hold, then R2 release
        cur_req = "R3";
        por_n = 1'b0; trap = 1'b1; tick(); trap = 1'b0; tick(); tick();
        chk("R3 kind poweron", int'(kind), 0);
        chk("R3 busy low in hold", int'(busy), 0);
        cur_req = "R2";
        por_n = 1'b1; tick();
        chk("R2 reset grant after rise", int'(grant), 1);
        finish_handling();
        // R5: after end-of-reset-handling no interrupt; trap discarded in hold (R3)
        cur_req = "R5";
        irq = 1'b1; ivec = 8'd33;
        boundary(3'd3);
        chk("R5 no irq after reset handling", int'(grant), 0);
        boundary(3'd2);
        chk("R5 no irq after ctrl modify", int'(grant), 0);
        cur_req = "R8";
        boundary(3'd0);
        chk("R8 irq grant", int'(grant), 4);
        chk("R8 irq vector", int'(vaddr), BASE + 4*33);
        // R9: boundaries while busy ignored
        cur_req = "R9";
        boundary(3'd0); boundary(3'd0);
        chk("R9 no grant while busy", int'(grant), 0);
        finish_handling();
        irq = 1'b0;

        // R4: trace gating
        cur_req = "R4";
        tflag = 1'b1; mode = 2'd2;
        boundary(3'd1);
        chk("R4 no trace after return", int'(grant), 0);
        boundary(3'd0);
        chk("R4 trace granted", int'(grant), 2);
        finish_handling();
        mode = 2'd0;
        boundary(3'd0);
        chk("R4 no trace in mode 0", int'(grant), 0);

        // R6 / R1: trap waits behind trace and interrupt
        cur_req = "R6";
        mode = 2'd2; trap = 1'b1; tick(); trap = 1'b0;
        cur_req = "R1";
        boundary(3'd0);
        chk("R1 trace beats trap", int'(grant), 2);
        finish_handling();
        tflag = 1'b0; irq = 1'b1; ivec = 8'd7;
        boundary(3'd0);
        chk("R1 irq beats trap", int'(grant), 4);
        finish_handling();
        irq = 1'b0;
        cur_req = "R6";
        boundary(3'd2);
        chk("R6 pending trap granted", int'(grant), 8);
        chk("R6 trap vector", int'(vaddr), BASE + 32);
        // R2: watchdog aborts busy handling
        cur_req = "R2";
        wdt = 1'b1; tick(); wdt = 1'b0;
        chk("R2 watchdog reset while busy", int'(grant), 1);
        finish_handling();

        // R7: unused class codes act as normal
        cur_req = "R7";
        irq = 1'b1; ivec = 8'd200; tflag = 1'b1; mode = 2'd2;
        boundary(3'd6);
        chk("R7 code 6 allows trace", int'(grant), 2);
        finish_handling();
        tflag = 1'b0;
        boundary(3'd5);
        chk("R7 code 5 allows irq", int'(grant), 4);
        finish_handling();
        irq = 1'b0;

        // R3: manual reset kind, both pins low
        cur_req = "R3";
        mrst_n = 1'b0; tick(); tick();
        chk("R3 manual kind", int'(kind), 1);
        por_n = 1'b0; tick();
        chk("R3 poweron wins", int'(kind), 0);
        por_n = 1'b1; tick(); mrst_n = 1'b1; tick();
        chk("R3 kind after release", int'(kind), 1);
        finish_handling();

        // R1: random mix against the model
        cur_req = "R1";
        for (int i = 0; i < 4000; i++) begin
            por_n  = ($urandom % 97) != 0;
            mrst_n = ($urandom % 89) != 0;
            wdt    = ($urandom % 113) == 0;
            tflag  = $urandom % 2;
            mode   = 2'($urandom % 4);
            irq    = $urandom % 2;
            ivec   = 8'($urandom % 256);
            trap   = ($urandom % 6) == 0;
            bnd    = $urandom % 2;
            cls    = 3'($urandom % 8);
            done   = ($urandom % 4) == 0;
            tick();
        end
        por_n = 1'b1; mrst_n = 1'b1; wdt = 1'b0; bnd = 1'b0; trap = 1'b0; done = 1'b0;
        tick();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule